// File: doc/BRIEF.md
# Crossover-Resolving Link Bring-Up Sequencer

This block brings up a twisted-pair port whose cable may be straight or crossed. It reads a PHY's management registers through a packed access word. It writes that word out with a request bit set, then watches the readback until the request bit clears. It drives a crossover select that starts in straight (MDI) mode. After every poll that finds no link, it swaps between straight and crossed. It gives up after a fixed number of polls, and a programmable tick count sets the spacing between polls.

Once link is seen, the sequencer works out the line state from the same status read. It reads a vendor status register for the speed code only if negotiation has completed. It then walks a short chain of capability reads to decide whether pause is granted, and stops at the first register that refuses it. The result is written to a four-flag status word, and a one-cycle `done` pulse marks the end of the sequence. A failed bring-up raises `link_fail` and leaves the previous status word in place.

The management serial shifter is outside the block. It is seen only as a responder that shows the request bit set while busy and clears it when the data is valid.

Top module: `mdix_link_seq`

## Requirements
- R1: After reset: `mdix_sel`=0, `stat_word`=0, `link_fail`=0, `done`=0, `acc_wr`=0.
- R2: Every access is a one-cycle `acc_wr` strobe with `acc_word` bit 31=1 (request), bit 30=0 (read), bits 25:21=PHY_ADDR (default 6), bits 20:16 = register number, bits 15:0 = 0. No new strobe is issued until a readback with bit 31=0 has been taken.
- R3: After `start`, at least POLL_TICKS cycles pass before each link poll (a read of register 1). The first poll is made with `mdix_sel`=0. Each poll whose bit 2 reads 0 inverts `mdix_sel` before the next poll.
- R4: After MAX_TRIES polls with no link, `link_fail` rises together with a `done` pulse, `stat_word` keeps its old value, and no further access is made.
- R5: A poll with register 1 bit 2 set ends polling. `mdix_sel` keeps the value it had during that poll.
- R6: If register 1 bit 5 (negotiation complete) is 0 in the link-up poll, no further register is read, and only the link flag is set.
- R7: The speed code is register 31 bits 4:2. Code 1 means 10 Mb/s half, 5 means 10 Mb/s full, 2 means 100 Mb/s half and 6 means 100 Mb/s full. Any other code clears both the speed flag and the duplex flag.
- R8: Pause needs register 1 bit 3, register 6 bit 0, register 4 bit 10 and register 5 bit 10 all set. Registers 6, 4 and 5 are read in that order, after register 31, and the chain stops at the first zero.
- R9: On success a `done` pulse is given with `link_fail`=0 and `stat_word` = {pause, full duplex, 100 Mb/s, link up} (bit 3 down to bit 0). Bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a bring-up sequence when idle |
| acc_rdata | input | 32 | Readback of the access word; bit 31 = busy, bits 15:0 = data |
| acc_wr | output | 1 | One-cycle write strobe for the access word |
| acc_word | output | 32 | Access word being written |
| mdix_sel | output | 1 | Crossover select, 0 = straight, 1 = crossed |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| link_fail | output | 1 | Set when all polls found no link; cleared by `start` |
| stat_word | output | 4 | {pause, full, fast, up} status flags |

## Verification
The assertions assume the responder shows bit 31 set in the readback from the second cycle after a strobe onward. They also assume it never clears bit 31 before the data in bits 15:0 is final. The bench's PHY model latches each strobe at the clock edge and holds busy for several cycles, so this always holds. It also assumes `start` is raised only while the block is idle, so the bench pulses `start` once and then waits for `done`. Each case in the vector table sets the failed-poll count and the register bits before `start`. The model then records the select value at every poll and the order of all other reads.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ISSUE, S_SETTLE, S_POLL, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    P_BSR, P_SCSR, P_EXP, P_ADV, P_LPA
  } seq_phase_t;

  localparam logic [4:0] REG_BSR  = 5'd1;
  localparam logic [4:0] REG_SCSR = 5'd31;
  localparam logic [4:0] REG_EXP  = 5'd6;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;
endpackage

// File: rtl/mdix_tick_timer.sv
module mdix_tick_timer #(
  parameter int TICKS = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (arm) begin
        cnt <= CW'(TICKS - 1);
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3: the expiry is a single pulse per arming
  a_r3_expire_once: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
endmodule

// File: rtl/mdix_speed_map.sv
module mdix_speed_map (
  input  logic [2:0] code,
  output logic       fast,
  output logic       full
);
  always_comb begin
    fast = 1'b0;
    full = 1'b0;
    case (code)
      3'd1: begin fast = 1'b0; full = 1'b0; end
      3'd5: begin fast = 1'b0; full = 1'b1; end
      3'd2: begin fast = 1'b1; full = 1'b0; end
      3'd6: begin fast = 1'b1; full = 1'b1; end
      default: begin fast = 1'b0; full = 1'b0; end
    endcase
  end
endmodule

// File: rtl/mdix_link_seq.sv
module mdix_link_seq
  import mdix_pkg::*;
#(
  parameter int         MAX_TRIES  = 100,
  parameter int         POLL_TICKS = 200_000_000,
  parameter logic [4:0] PHY_ADDR   = 5'd6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] acc_rdata,
  output logic        acc_wr,
  output logic [31:0] acc_word,
  output logic        mdix_sel,
  output logic        done,
  output logic        link_fail,
  output logic [3:0]  stat_word
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  seq_state_t    state;
  seq_phase_t    phase;
  logic [TW-1:0] tries;
  logic [15:0]   bsr_q;
  logic          spd_q, dup_q, pse_q;
  logic          arm, tmr_exp;
  logic [4:0]    reg_sel;
  logic          map_fast, map_full;
  logic          rd_ready;

  mdix_tick_timer #(.TICKS(POLL_TICKS)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .expired(tmr_exp)
  );

  mdix_speed_map u_map (
    .code(acc_rdata[4:2]), .fast(map_fast), .full(map_full)
  );

  always_comb begin
    case (phase)
      P_SCSR:  reg_sel = REG_SCSR;
      P_EXP:   reg_sel = REG_EXP;
      P_ADV:   reg_sel = REG_ADV;
      P_LPA:   reg_sel = REG_LPA;
      default: reg_sel = REG_BSR;
    endcase
  end

  assign rd_ready = (state == S_POLL) && !acc_rdata[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= P_BSR;
      tries     <= '0;
      bsr_q     <= '0;
      spd_q     <= 1'b0;
      dup_q     <= 1'b0;
      pse_q     <= 1'b0;
      arm       <= 1'b0;
      acc_wr    <= 1'b0;
      acc_word  <= '0;
      mdix_sel  <= 1'b0;
      done      <= 1'b0;
      link_fail <= 1'b0;
      stat_word <= '0;
    end else begin
      acc_wr <= 1'b0;
      arm    <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mdix_sel  <= 1'b0;
          tries     <= '0;
          link_fail <= 1'b0;
          phase     <= P_BSR;
          spd_q     <= 1'b0;
          dup_q     <= 1'b0;
          pse_q     <= 1'b0;
          arm       <= 1'b1;
          state     <= S_WAIT;
        end
        S_WAIT: if (tmr_exp) state <= S_ISSUE;
        S_ISSUE: begin
          acc_wr   <= 1'b1;
          acc_word <= {1'b1, 1'b0, 4'd0, PHY_ADDR, reg_sel, 16'd0};
          state    <= S_SETTLE;
        end
        S_SETTLE: state <= S_POLL;
        S_POLL: if (rd_ready) begin
          case (phase)
            P_BSR: begin
              if (!acc_rdata[2]) begin
                if (tries == TW'(MAX_TRIES - 1)) begin
                  link_fail <= 1'b1;
                  done      <= 1'b1;
                  state     <= S_IDLE;
                end else begin
                  tries    <= tries + 1'b1;
                  mdix_sel <= ~mdix_sel;
                  arm      <= 1'b1;
                  state    <= S_WAIT;
                end
              end else begin
                bsr_q <= acc_rdata[15:0];
                if (acc_rdata[5]) begin
                  phase <= P_SCSR;
                  state <= S_ISSUE;
                end else begin
                  state <= S_DONE;
                end
              end
            end
            P_SCSR: begin
              spd_q <= map_fast;
              dup_q <= map_full;
              if (bsr_q[3]) begin
                phase <= P_EXP;
                state <= S_ISSUE;
              end else begin
                state <= S_DONE;
              end
            end
            P_EXP: if (acc_rdata[0]) begin
              phase <= P_ADV;
              state <= S_ISSUE;
            end else begin
              state <= S_DONE;
            end
            P_ADV: if (acc_rdata[10]) begin
              phase <= P_LPA;
              state <= S_ISSUE;
            end else begin
              state <= S_DONE;
            end
            default: begin
              pse_q <= acc_rdata[10];
              state <= S_DONE;
            end
          endcase
        end
        S_DONE: begin
          stat_word <= {pse_q, dup_q, spd_q, 1'b1};
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a request strobe lasts one cycle and carries a read to the target PHY
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> !acc_wr);
  a_r2_read_fields: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> (acc_word[31] && !acc_word[30] && acc_word[25:21] == PHY_ADDR));
  // R3: re-entering the wait after a poll means the select was swapped
  a_r3_swap_on_miss: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && $past(state) == S_POLL) |-> (mdix_sel != $past(mdix_sel)));
  // R4: the retry count never passes its bound; a failure keeps the status
  a_r4_try_bound: assert property (@(posedge clk) disable iff (rst)
    tries < TW'(MAX_TRIES));
  a_r4_status_kept: assert property (@(posedge clk) disable iff (rst)
    $rose(link_fail) |-> $stable(stat_word));
  // R9: a successful end always reports link up
  a_r9_link_flag: assert property (@(posedge clk) disable iff (rst)
    (done && !link_fail) |-> stat_word[0]);
endmodule

// File: tb/sim_mdix_link_seq.sv
module sim_mdix_link_seq;
  localparam int MAXT  = 6;
  localparam int TICKS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] acc_rdata;
  logic        acc_wr;
  logic [31:0] acc_word;
  logic        mdix_sel, done, link_fail;
  logic [3:0]  stat_word;

  always #5 clk = ~clk;

  mdix_link_seq #(.MAX_TRIES(MAXT), .POLL_TICKS(TICKS), .PHY_ADDR(5'd6)) u0 (
    .clk(clk), .rst(rst), .start(start), .acc_rdata(acc_rdata),
    .acc_wr(acc_wr), .acc_word(acc_word), .mdix_sel(mdix_sel),
    .done(done), .link_fail(link_fail), .stat_word(stat_word)
  );

  int checks = 0;
  int errors = 0;

  // PHY model settings for the running case
  int         v_fail = 0;
  logic       v_b5 = 0, v_b3 = 0, v_e0 = 0, v_a10 = 0, v_l10 = 0;
  logic [2:0] v_code = 0;
  logic       clr = 0;

  // PHY model state
  logic        busy;
  int          lat;
  logic [15:0] rsp;
  int          polls, others, sel_err, fld_err, ovl_err, cyc, start_cyc, first_gap;
  logic [19:0] log_q;

  assign acc_rdata = {busy, 15'd0, rsp};

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (start) start_cyc <= cyc;
    if (rst) begin
      busy <= 1'b0;
      lat  <= 0;
      rsp  <= '0;
    end else if (acc_wr) begin
      if (busy) ovl_err <= ovl_err + 1;
      if (!acc_word[31] || acc_word[30] || acc_word[25:21] != 5'd6 || acc_word[15:0] != 16'd0)
        fld_err <= fld_err + 1;
      busy <= 1'b1;
      lat  <= 3;
      case (acc_word[20:16])
        5'd1: begin
          if (mdix_sel != polls[0]) sel_err <= sel_err + 1;
          if (polls == 0) first_gap <= cyc - start_cyc;
          polls <= polls + 1;
          rsp <= {10'd0, v_b5, 1'b0, v_b3, (polls + 1 > v_fail), 2'b00};
        end
        5'd31: rsp <= {11'd0, v_code, 2'b00};
        5'd6:  rsp <= {15'd0, v_e0};
        5'd4:  rsp <= {5'd0, v_a10, 10'd0};
        5'd5:  rsp <= {5'd0, v_l10, 10'd0};
        default: rsp <= 16'hDEAD;
      endcase
      if (acc_word[20:16] != 5'd1) begin
        others <= others + 1;
        log_q  <= {log_q[14:0], acc_word[20:16]};
      end
    end else if (busy) begin
      if (lat == 0) busy <= 1'b0;
      else lat <= lat - 1;
    end
    if (clr) begin
      polls <= 0; others <= 0; sel_err <= 0; fld_err <= 0; ovl_err <= 0;
      log_q <= '0; first_gap <= 0;
    end
  end

  typedef struct packed {
    logic [7:0]  fail_polls;
    logic        b5, b3;
    logic [2:0]  code;
    logic        e0, a10, l10;
    logic [3:0]  stat;
    logic        fail;
    logic        sel;
    logic [19:0] log;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, {5'd31, 5'd6, 5'd4, 5'd5}},
    '{8'd3, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 4'h1, 1'b0, 1'b1, {5'd0, 5'd0, 5'd0, 5'd31}},
    '{8'd1, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0, 1'b1, {5'd0, 5'd0, 5'd31, 5'd6}},
    '{8'd2, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 4'h3, 1'b0, 1'b0, {5'd0, 5'd31, 5'd6, 5'd4}},
    '{8'd0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 4'h7, 1'b0, 1'b0, {5'd31, 5'd6, 5'd4, 5'd5}},
    '{8'd0, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 4'h1, 1'b0, 1'b0, 20'd0},
    '{8'd5, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 4'h9, 1'b0, 1'b1, {5'd31, 5'd6, 5'd4, 5'd5}},
    '{8'd9, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 4'h9, 1'b1, 1'b1, 20'd0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(output bit ok);
    ok = 1'b0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      errors++; checks++;
      $display("FAIL R9 done: actual 0 expected 1");
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    cyc = 0;
    @(negedge clk); clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    // R1: reset values
    check("R1", "mdix_sel", mdix_sel, 0);
    check("R1", "stat_word", stat_word, 0);
    check("R1", "link_fail", link_fail, 0);
    check("R1", "done", done, 0);
    check("R1", "acc_wr", acc_wr, 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      v_fail = VECS[k].fail_polls;
      v_b5 = VECS[k].b5; v_b3 = VECS[k].b3; v_code = VECS[k].code;
      v_e0 = VECS[k].e0; v_a10 = VECS[k].a10; v_l10 = VECS[k].l10;
      run_seq(ok);
      if (ok) begin
        check(VECS[k].fail ? "R4" : "R9", "stat_word", stat_word, VECS[k].stat);
        check(VECS[k].fail ? "R4" : "R9", "link_fail", link_fail, VECS[k].fail);
        check("R5", "mdix_sel at end", mdix_sel, VECS[k].sel);
        check("R3", "select per poll", sel_err, 0);
        check("R3", "first poll spacing", int'(first_gap >= TICKS), 1);
        check("R4", "poll count", polls, VECS[k].fail ? MAXT : VECS[k].fail_polls + 1);
        check("R8", "read order", log_q, VECS[k].log);
        check("R6", "extra reads", others,
              (VECS[k].log[19:15] != 0) ? 4 : (VECS[k].log[14:10] != 0) ? 3 :
              (VECS[k].log[9:5] != 0) ? 2 : (VECS[k].log[4:0] != 0) ? 1 : 0);
        check("R2", "field errors", fld_err, 0);
        check("R2", "overlapping requests", ovl_err, 0);
      end
    end

    // R4: no access after a failed sequence
    repeat (30) @(negedge clk);
    check("R4", "idle after failure", polls + others, MAXT);

    // R7: unknown code 7 clears speed and duplex, no pause path
    v_fail = 0; v_b5 = 1; v_b3 = 0; v_code = 3'd7;
    run_seq(ok);
    if (ok) check("R7", "unknown code", stat_word, 4'h1);

    // R1: reset in the middle of a sequence
    v_fail = 20;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "mid-run mdix_sel", mdix_sel, 0);
    check("R1", "mid-run stat_word", stat_word, 0);
    check("R1", "mid-run acc_wr", acc_wr, 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule